// File: doc/BRIEF.md
# Tamper Event Interrupt and Wakeup Controller

This block collects single-cycle event pulses from a parameterised set of external tamper detectors and internal tamper sources. Each pulse is captured in a sticky status flag. The flags are combined with software interrupt enables into a masked status word, and a single level interrupt is raised from that word. A 32-bit word register port gives software access to the enables, the raw flags and the masked flags, and a write-one-to-clear register removes flags.

The block also produces a wakeup request for a power controller. A pending enabled event always wakes the system from run/sleep. In the deeper modes an external source whose detector runs in filtered level mode can only wake the system if the low-speed clock that keeps the filter running survives in that mode. In stop and standby that clock is the low-speed external or the low-speed internal oscillator. In shutdown only the low-speed external oscillator qualifies. Internal sources, and external sources in any other detection mode, are not restricted.

Top module: `tamper_wake_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released with no activity, all flags and enables are 0, every register reads 0, and irq_o and wake_o are low.
- R2: A high ext_evt_i[x] or int_evt_i[y] at a rising clock edge sets the matching status flag. The flag reads back at offset 0x04 from the next cycle on and stays set until it is cleared.
- R3: Writing a word to offset 0x0C clears each flag whose bit is 1 in the data. Bits written as 0 have no effect, and writes to offsets 0x04 and 0x08 change nothing.
- R4: When an event and a write-1 clear hit the same flag in the same cycle, the flag stays set.
- R5: Offset 0x00 is the read/write enable register, and only the bits of existing sources hold a value. Offset 0x08 reads status AND enable. Offset 0x0C and undefined offsets read 0.
- R6: irq_o is high exactly while at least one masked status bit is set.
- R7: In mode 0 (run/sleep), wake_o equals irq_o, whatever the detection modes and clock source are.
- R8: In mode 1 (stop) or mode 2 (standby), a masked external source with ext_filt_i set contributes to wake_o only when clk_src_i is 0 (low-speed external) or 1 (low-speed internal). Every other masked source always contributes.
- R9: In mode 3 (shutdown), a masked external source with ext_filt_i set contributes to wake_o only when clk_src_i is 0. Every other masked source always contributes.
- R10: In the status, enable and masked words, external source x sits at bit x and internal source y at bit 16+y.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_evt_i | input | N_EXT | Event pulses from the external tamper detectors |
| int_evt_i | input | N_INT | Event pulses from the internal tamper sources |
| ext_filt_i | input | N_EXT | 1 = that external detector runs in filtered level mode |
| lp_mode_i | input | 2 | Low-power mode: 0 run/sleep, 1 stop, 2 standby, 3 shutdown |
| clk_src_i | input | 2 | Block clock: 0 low-speed external, 1 low-speed internal, 2/3 other |
| reg_addr_i | input | AW | Byte offset of the register access |
| reg_wr_i | input | 1 | Write strobe, taken at the rising edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 1 | Level interrupt |
| wake_o | output | 1 | Wakeup request |

## Verification
A new event and a software clear can land on the same flag in the same clock cycle. The bench first sets a flag, then in one cycle drives that source's event pulse together with a write of 1 to the clear register. Reading status afterwards must still show the bit set. A second case does the same on one bit while clearing a different bit in the same write, and only the other bit must drop.

// File: rtl/tamp_evt_pkg.sv
package tamp_evt_pkg;

  localparam int unsigned REG_W    = 32;
  localparam int unsigned INT_BASE = 16;

  localparam logic [7:0] OFF_ENABLE = 8'h00;
  localparam logic [7:0] OFF_STATUS = 8'h04;
  localparam logic [7:0] OFF_MASKED = 8'h08;
  localparam logic [7:0] OFF_CLEAR  = 8'h0C;

  typedef enum logic [1:0] {
    LP_RUN      = 2'd0,
    LP_STOP     = 2'd1,
    LP_STANDBY  = 2'd2,
    LP_SHUTDOWN = 2'd3
  } lp_mode_e;

  typedef enum logic [1:0] {
    CK_LSE   = 2'd0,
    CK_LSI   = 2'd1,
    CK_OTHER = 2'd2,
    CK_RSVD  = 2'd3
  } clk_src_e;

endpackage

// File: rtl/tamp_flag_bank.sv
module tamp_flag_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);

  for (genvar i = 0; i < W; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q <= 1'b0;
      else if (evt_i[i])  flag_q <= 1'b1;   // event beats clear
      else if (clr_i[i])  flag_q <= 1'b0;
    end
    assign flag_o[i] = flag_q;
  end

endmodule

// File: rtl/tamp_regif.sv
module tamp_regif
  import tamp_evt_pkg::*;
#(
  parameter int unsigned N_EXT = 4,
  parameter int unsigned N_INT = 3,
  parameter int unsigned AW    = 8,
  localparam int unsigned W    = N_EXT + N_INT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [W-1:0]     flag_i,
  output logic [W-1:0]     en_o,
  output logic [W-1:0]     masked_o,
  output logic [W-1:0]     clr_o,
  output logic [REG_W-1:0] rdata_o
);

  logic [REG_W-1:0] wdata_unused;
  logic [W-1:0]     wsrc;
  logic [W-1:0]     en_q;
  logic [REG_W-1:0] en_word, st_word, mk_word;
  logic             sel_en, sel_st, sel_mk, sel_clr;

  assign sel_en  = (addr_i == AW'(OFF_ENABLE));
  assign sel_st  = (addr_i == AW'(OFF_STATUS));
  assign sel_mk  = (addr_i == AW'(OFF_MASKED));
  assign sel_clr = (addr_i == AW'(OFF_CLEAR));

  // word <-> source vector mapping: ext at bit x, int at INT_BASE+y
  for (genvar x = 0; x < N_EXT; x++) begin : g_ext_map
    assign wsrc[x] = wdata_i[x];
  end
  for (genvar y = 0; y < N_INT; y++) begin : g_int_map
    assign wsrc[N_EXT+y] = wdata_i[INT_BASE+y];
  end
  assign wdata_unused = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             en_q <= '0;
    else if (wr_i && sel_en) en_q <= wsrc;
  end

  assign en_o     = en_q;
  assign masked_o = flag_i & en_q;
  assign clr_o    = (wr_i && sel_clr) ? wsrc : '0;

  always_comb begin
    en_word = '0;
    st_word = '0;
    mk_word = '0;
    for (int x = 0; x < N_EXT; x++) begin
      en_word[x] = en_q[x];
      st_word[x] = flag_i[x];
      mk_word[x] = masked_o[x];
    end
    for (int y = 0; y < N_INT; y++) begin
      en_word[INT_BASE+y] = en_q[N_EXT+y];
      st_word[INT_BASE+y] = flag_i[N_EXT+y];
      mk_word[INT_BASE+y] = masked_o[N_EXT+y];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_en)      rdata_o = en_word;
    else if (sel_st) rdata_o = st_word;
    else if (sel_mk) rdata_o = mk_word;
  end

endmodule

// File: rtl/tamp_wake_gate.sv
module tamp_wake_gate
  import tamp_evt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] masked_i,
  input  logic [W-1:0] filt_i,
  input  logic [1:0]   lp_mode_i,
  input  logic [1:0]   clk_src_i,
  output logic         wake_o
);

  lp_mode_e mode;
  clk_src_e src;
  logic     filt_ok;
  logic [W-1:0] elig;

  assign mode = lp_mode_e'(lp_mode_i);
  assign src  = clk_src_e'(clk_src_i);

  // can a filtered level detector keep running in this mode?
  always_comb begin
    unique case (mode)
      LP_RUN:                filt_ok = 1'b1;
      LP_STOP, LP_STANDBY:   filt_ok = (src == CK_LSE) || (src == CK_LSI);
      LP_SHUTDOWN:           filt_ok = (src == CK_LSE);
      default:               filt_ok = 1'b0;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_elig
    assign elig[i] = masked_i[i] & (~filt_i[i] | filt_ok);
  end

  assign wake_o = |elig;

endmodule

// File: rtl/tamper_wake_ctrl.sv
module tamper_wake_ctrl
  import tamp_evt_pkg::*;
#(
  parameter int unsigned N_EXT = 4,
  parameter int unsigned N_INT = 3,
  parameter int unsigned AW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] ext_evt_i,
  input  logic [N_INT-1:0] int_evt_i,
  input  logic [N_EXT-1:0] ext_filt_i,
  input  logic [1:0]       lp_mode_i,
  input  logic [1:0]       clk_src_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic             reg_wr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             irq_o,
  output logic             wake_o
);

  localparam int unsigned W = N_EXT + N_INT;

  logic [W-1:0] evt_vec, clr_vec, flags_q, en_q, masked, filt_w;

  assign evt_vec = {int_evt_i, ext_evt_i};
  assign filt_w  = {{N_INT{1'b0}}, ext_filt_i};

  tamp_regif #(.N_EXT(N_EXT), .N_INT(N_INT), .AW(AW)) u_regif (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (reg_addr_i),
    .wr_i     (reg_wr_i),
    .wdata_i  (reg_wdata_i),
    .flag_i   (flags_q),
    .en_o     (en_q),
    .masked_o (masked),
    .clr_o    (clr_vec),
    .rdata_o  (reg_rdata_o)
  );

  tamp_flag_bank #(.W(W)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_vec),
    .clr_i  (clr_vec),
    .flag_o (flags_q)
  );

  tamp_wake_gate #(.W(W)) u_wake (
    .masked_i  (masked),
    .filt_i    (filt_w),
    .lp_mode_i (lp_mode_i),
    .clk_src_i (clk_src_i),
    .wake_o    (wake_o)
  );

  assign irq_o = |masked;

endmodule

// File: rtl/tamp_evt_chk.sv
module tamp_evt_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] evt_i,
  input logic [W-1:0] clr_i,
  input logic [W-1:0] flags_i,
  input logic [W-1:0] en_i,
  input logic [W-1:0] masked_i,
  input logic [W-1:0] filt_i,
  input logic [1:0]   lp_mode_i,
  input logic [1:0]   clk_src_i,
  input logic         irq_i,
  input logic         wake_i
);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (flags_i == '0 && en_i == '0 && !irq_i && !wake_i)
        else $error("a_r1_reset_quiet");
    end
  end

  a_r2_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flags_i & $past(evt_i)) == $past(evt_i)));

  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((flags_i & $past(flags_i)) == $past(flags_i)));

  a_r3_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~evt_i) != '0) |=> ((flags_i & $past(clr_i & ~evt_i)) == '0));

  a_r4_evt_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & clr_i) != '0) |=> ((flags_i & $past(evt_i & clr_i)) == $past(evt_i & clr_i)));

  a_r5_masked_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((masked_i & ~flags_i) == '0) && ((masked_i & ~en_i) == '0));

  a_r6_no_flag_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i == '0) |-> !irq_i);

  a_r7_run_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_mode_i == 2'd0) |-> (wake_i == irq_i));

  a_r8_stop_other_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lp_mode_i == 2'd1 || lp_mode_i == 2'd2) && clk_src_i[1] && wake_i)
      |-> ((masked_i & ~filt_i) != '0));

  a_r9_shutdown_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_mode_i == 2'd3 && clk_src_i != 2'd0 && wake_i) |-> ((masked_i & ~filt_i) != '0));

endmodule

bind tamper_wake_ctrl tamp_evt_chk #(.W(N_EXT + N_INT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .evt_i     (evt_vec),
  .clr_i     (clr_vec),
  .flags_i   (flags_q),
  .en_i      (en_q),
  .masked_i  (masked),
  .filt_i    (filt_w),
  .lp_mode_i (lp_mode_i),
  .clk_src_i (clk_src_i),
  .irq_i     (irq_o),
  .wake_i    (wake_o)
);

// File: tb/tb_tamper_wake_ctrl.sv
module tb_tamper_wake_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int N_EXT = 4;
  localparam int N_INT = 3;
  localparam int AW    = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N_EXT-1:0] ext_evt = '0;
  logic [N_INT-1:0] int_evt = '0;
  logic [N_EXT-1:0] ext_filt = '0;
  logic [1:0]       lp_mode = 2'd0;
  logic [1:0]       clk_src = 2'd2;
  logic [AW-1:0]    addr = '0;
  logic             wr = 1'b0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic             irq, wake;

  always #(CLK_PERIOD/2) clk = ~clk;

  tamper_wake_ctrl #(.N_EXT(N_EXT), .N_INT(N_INT), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_evt_i(ext_evt), .int_evt_i(int_evt),
    .ext_filt_i(ext_filt), .lp_mode_i(lp_mode), .clk_src_i(clk_src),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  typedef struct {
    int          kind;   // 0 rdata, 1 irq, 2 wake
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_vec = 0;
  int n_bad = 0;

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = rdata;
        1:       act = {31'd0, irq};
        default: act = {31'd0, wake};
      endcase
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    addr = a;
    q.push_back('{0, e, tag});
    @(negedge clk); #1;
  endtask

  task automatic expect_pin(input int kind, input logic e, input string tag);
    q.push_back('{kind, {31'd0, e}, tag});
    @(negedge clk); #1;
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0;
  endtask

  task automatic pulse(input logic [N_EXT-1:0] e, input logic [N_INT-1:0] i);
    @(posedge clk); #1;
    ext_evt = e; int_evt = i;
    tick();
    ext_evt = '0; int_evt = '0;
  endtask

  task automatic pulse_and_clear(input logic [N_EXT-1:0] e, input logic [31:0] c);
    @(posedge clk); #1;
    ext_evt = e; addr = 8'h0C; wdata = c; wr = 1'b1;
    tick();
    ext_evt = '0; wr = 1'b0;
  endtask

  task automatic set_pm(input logic [1:0] m, input logic [1:0] c);
    lp_mode = m; clk_src = c;
    #1;
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(posedge clk);
    // R1: during reset
    expect_pin(1, 1'b0, "R1 irq in reset");
    expect_pin(2, 1'b0, "R1 wake in reset");
    #2 rst_ni = 1'b1;
    tick();
    expect_rd(8'h00, 32'h0, "R1 enable after reset");
    expect_rd(8'h04, 32'h0, "R1 status after reset");
    expect_rd(8'h08, 32'h0, "R1 masked after reset");
    expect_rd(8'h0C, 32'h0, "R5 clear reads zero");

    // R5/R10: only existing bits hold
    reg_write(8'h00, 32'hFFFF_FFFF);
    expect_rd(8'h00, 32'h0007_000F, "R5 R10 enable implemented bits");
    expect_rd(8'h40, 32'h0, "R5 undefined offset");

    // R2/R10
    pulse(4'b0100, 3'b000);
    expect_rd(8'h04, 32'h0000_0004, "R2 R10 ext2 flag");
    expect_pin(1, 1'b1, "R6 irq with masked bit");
    repeat (4) tick();
    expect_rd(8'h04, 32'h0000_0004, "R2 flag sticky");
    pulse(4'b0000, 3'b010);
    expect_rd(8'h04, 32'h0002_0004, "R10 int1 at bit 17");

    // R3
    reg_write(8'h0C, 32'h0);
    expect_rd(8'h04, 32'h0002_0004, "R3 write zero no effect");
    reg_write(8'h04, 32'h0);
    reg_write(8'h08, 32'h0);
    expect_rd(8'h04, 32'h0002_0004, "R3 status/masked writes ignored");
    reg_write(8'h0C, 32'h0000_0004);
    expect_rd(8'h04, 32'h0002_0000, "R3 clear ext2");

    // R4
    pulse(4'b0001, 3'b000);
    expect_rd(8'h04, 32'h0002_0001, "R4 setup");
    pulse_and_clear(4'b0001, 32'h0000_0001);
    expect_rd(8'h04, 32'h0002_0001, "R4 event beats clear");
    pulse_and_clear(4'b0001, 32'h0002_0001);
    expect_rd(8'h04, 32'h0000_0001, "R4 other bit cleared same write");
    pulse(4'b0000, 3'b010);

    // R5/R6
    reg_write(8'h00, 32'h0002_0000);
    expect_rd(8'h08, 32'h0002_0000, "R5 masked = status & enable");
    expect_pin(1, 1'b1, "R6 irq high");
    reg_write(8'h00, 32'h0);
    expect_rd(8'h08, 32'h0, "R5 masked all disabled");
    expect_pin(1, 1'b0, "R6 irq low when masked empty");
    expect_pin(2, 1'b0, "R7 no wake without enable");

    // wake gating: only ext1 pending, filtered
    reg_write(8'h0C, 32'hFFFF_FFFF);
    reg_write(8'h00, 32'hFFFF_FFFF);
    ext_filt = 4'b0010;
    pulse(4'b0010, 3'b000);
    expect_rd(8'h08, 32'h0000_0002, "R8 setup masked");
    set_pm(2'd0, 2'd2); expect_pin(2, 1'b1, "R7 run wakes any clk");
    set_pm(2'd1, 2'd2); expect_pin(2, 1'b0, "R8 stop other clk blocked");
    set_pm(2'd1, 2'd1); expect_pin(2, 1'b1, "R8 stop lsi ok");
    set_pm(2'd2, 2'd0); expect_pin(2, 1'b1, "R8 standby lse ok");
    set_pm(2'd2, 2'd3); expect_pin(2, 1'b0, "R8 standby clk3 blocked");
    set_pm(2'd3, 2'd1); expect_pin(2, 1'b0, "R9 shutdown lsi blocked");
    set_pm(2'd3, 2'd0); expect_pin(2, 1'b1, "R9 shutdown lse ok");
    ext_filt = 4'b0000;
    set_pm(2'd3, 2'd2); expect_pin(2, 1'b1, "R9 unfiltered ext wakes");
    ext_filt = 4'b0010;
    pulse(4'b0000, 3'b001);
    set_pm(2'd3, 2'd2); expect_pin(2, 1'b1, "R9 internal source wakes");
    reg_write(8'h0C, 32'h0001_0000);
    pulse(4'b1000, 3'b000);
    set_pm(2'd1, 2'd2); expect_pin(2, 1'b1, "R8 unfiltered ext3 wakes");

    repeat (2) tick();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule